// File: doc/BRIEF.md
# GMSK Baseband Modulator

This block turns a serial stream of data bits into oversampled complex baseband samples of a Gaussian minimum-shift-keyed waveform. Each accepted bit becomes a bipolar level. A short Gaussian pulse shapes that level into an instantaneous frequency, which is sampled four times per symbol. The frequency is summed into a wrapping phase register. The phase of each sample is then turned into a cosine/sine pair by a single iterative CORDIC rotator.

The upstream source offers one bit at a time on a valid/ready pair. The modulator takes a new bit only after it has emitted all four samples of the previous one, so the bit rate is set by how fast the modulator consumes. The downstream logic (interpolation, mixing, conversion) takes each I/Q pair in the cycle its strobe is high. The phase register is never reset between symbols, so the carrier phase stays continuous for as long as the block runs.

Top module: `gmsk_mod`

## Requirements
- R1: `in_ready` is high only while the modulator is idle. In the cycle after a bit is accepted (`in_valid` and `in_ready` both high), `in_ready` is low, and it stays low until all samples of that bit have been emitted.
- R2: Each accepted bit produces exactly 4 output samples. Each sample is marked by `out_valid` being high for exactly one cycle.
- R3: A bit value of 1 maps to level +1 and makes the phase rise (counter-clockwise, Q becomes positive when starting from phase 0). A bit value of 0 maps to level -1 and makes the phase fall.
- R4: The phase increment applied after sample k (k = 0..3) of the newest symbol is the sum over j = 0..2 of level(j) * tap[k + 4j]. Here j = 0 is the newest symbol, an empty history slot has level 0, and the 16-bit phase units are 1/65536 turn. The taps, indexed 0..11, are 156, 441, 985, 1711, 2333, 2566, 2566, 2333, 1711, 985, 441, 156.
- R5: With modulation index 0.5, the taps add up to 16384, so a symbol whose three-symbol window holds identical bits turns the phase by exactly a quarter turn. No single sample increment exceeds 4200 in magnitude.
- R6: The phase register wraps modulo 65536 and changes only at a sample step. Each sample reports the phase held before its own increment is added.
- R7: `out_i` and `out_q` equal 30000*cos and 30000*sin of the sample phase, within 48 LSB. Both are two's-complement signed values.
- R8: A synchronous reset clears the phase to 0, empties the three-symbol history, drops `out_valid` and raises `in_ready`. The first sample after reset is therefore (30000, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data bit is offered |
| in_ready | output | 1 | Modulator can take a bit this cycle |
| in_bit | input | 1 | Data bit value |
| out_valid | output | 1 | One-cycle strobe for a new I/Q sample |
| out_i | output | 16 | In-phase sample, signed |
| out_q | output | 16 | Quadrature sample, signed |

## Verification
The bound checker watches properties that hold on every cycle:
- the handshake stays closed until all four samples of a bit are out, and each strobe is a single cycle;
- every sample increment stays within the bound the modulation index allows;
- the phase register never moves outside a sample step, and the outputs never leave the amplitude envelope;
- reset leaves the phase at zero.

Whether the Gaussian weighting, the bit polarity, the exact quarter turn per steady symbol and the CORDIC accuracy are right can only be shown by the bench scenarios. The bench compares every sample against a phase model it computes on its own, and it also checks the ninety-degree rotation between consecutive symbols of a run of ones, including runs where the phase wraps.

// File: rtl/gmsk_pkg.sv
`timescale 1ns/1ps
package gmsk_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} mod_state_t;

  // One slot of the symbol history: live marks a slot filled since reset.
  typedef struct packed {
    logic live;
    logic one;
  } sym_t;

  // Gaussian frequency pulse, BT 0.3, three symbols at four samples each.
  localparam int TAP_COUNT = 12;

  function automatic int nrz_level(sym_t s);
    if (!s.live) return 0;
    return s.one ? 1 : -1;
  endfunction

  function automatic int gauss_half(int i);
    case (i)
      0: return 156;
      1: return 441;
      2: return 985;
      3: return 1711;
      4: return 2333;
      default: return 2566;
    endcase
  endfunction

  // Symmetric pulse; weights sum to a quarter turn of a 16-bit phase.
  function automatic int gauss_tap(int idx);
    if (idx < 0 || idx >= TAP_COUNT) return 0;
    return (idx < TAP_COUNT / 2) ? gauss_half(idx) : gauss_half(TAP_COUNT - 1 - idx);
  endfunction

  // atan(2^-i) expressed in 1/65536 of a turn.
  function automatic int atan_turn(int i);
    case (i)
      0: return 8192;
      1: return 4836;
      2: return 2555;
      3: return 1297;
      4: return 651;
      5: return 326;
      6: return 163;
      7: return 81;
      8: return 41;
      9: return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      default: return 0;
    endcase
  endfunction

  // Starting x that cancels the rotator's growth, for a target amplitude.
  function automatic int cordic_seed(int amp);
    longint prod;
    prod = longint'(amp) * 64'sd607253;
    return int'(prod / 64'sd1000000);
  endfunction

endpackage

// File: rtl/gmsk_shaper.sv
`timescale 1ns/1ps
module gmsk_shaper
  import gmsk_pkg::*;
#(
  parameter int OSR  = 4,
  parameter int SPAN = 3,
  parameter int FW   = 16,
  parameter int SW   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push,
  input  logic                 push_one,
  input  logic [SW-1:0]        sub,
  output logic signed [FW-1:0] freq
);

  sym_t hist [SPAN];
  logic signed [FW-1:0] term [SPAN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < SPAN; j++) hist[j] <= '0;
    end else if (push) begin
      for (int j = SPAN - 1; j > 0; j--) hist[j] <= hist[j-1];
      hist[0] <= '{live: 1'b1, one: push_one};
    end
  end

  // One weighted term per history slot; slot 0 holds the newest symbol.
  for (genvar j = 0; j < SPAN; j++) begin : g_term
    assign term[j] = FW'(nrz_level(hist[j]) * gauss_tap(int'(sub) + OSR * j));
  end

  always_comb begin
    int s;
    s = 0;
    for (int j = 0; j < SPAN; j++) s += int'(term[j]);
    freq = FW'(s);
  end

endmodule

// File: rtl/gmsk_phase_acc.sv
`timescale 1ns/1ps
module gmsk_phase_acc #(
  parameter int PH_W = 16,
  parameter int FW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [FW-1:0] freq,
  output logic [PH_W-1:0]      phase
);

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= phase + PH_W'(freq);
  end

endmodule

// File: rtl/gmsk_cordic.sv
`timescale 1ns/1ps
module gmsk_cordic
  import gmsk_pkg::*;
#(
  parameter int PH_W = 16,
  parameter int IQ_W = 16,
  parameter int ITER = 14,
  parameter int AMP  = 30000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [PH_W-1:0]        phase_in,
  output logic                   done,
  output logic signed [IQ_W-1:0] out_i,
  output logic signed [IQ_W-1:0] out_q
);

  localparam int XW    = IQ_W + 2;
  localparam int ZW    = PH_W + 2;
  localparam int CW    = $clog2(ITER + 1);
  localparam int SEED  = cordic_seed(AMP);

  logic signed [XW-1:0] x_q, y_q, x_n, y_n, sh_x, sh_y, map_i, map_q;
  logic signed [ZW-1:0] z_q, z_n, step_ang;
  logic [1:0]           quad_q;
  logic [CW-1:0]        cnt_q;
  logic                 busy_q;
  logic                 turn_down;
  logic                 last_iter;

  assign sh_x      = x_q >>> cnt_q;
  assign sh_y      = y_q >>> cnt_q;
  assign step_ang  = ZW'(atan_turn(int'(cnt_q)));
  assign turn_down = z_q[ZW-1];
  assign last_iter = (cnt_q == CW'(ITER - 1));

  always_comb begin
    if (turn_down) begin
      x_n = x_q + sh_y;
      y_n = y_q - sh_x;
      z_n = z_q + step_ang;
    end else begin
      x_n = x_q - sh_y;
      y_n = y_q + sh_x;
      z_n = z_q - step_ang;
    end
  end

  // Undo the quadrant fold applied at load time.
  always_comb begin
    case (quad_q)
      2'd0: begin map_i = x_n;  map_q = y_n;  end
      2'd1: begin map_i = -y_n; map_q = x_n;  end
      2'd2: begin map_i = -x_n; map_q = -y_n; end
      default: begin map_i = y_n; map_q = -x_n; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      quad_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
      out_i  <= '0;
      out_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        x_q    <= XW'(SEED);
        y_q    <= '0;
        z_q    <= {4'b0000, phase_in[PH_W-3:0]};
        quad_q <= phase_in[PH_W-1:PH_W-2];
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        x_q   <= x_n;
        y_q   <= y_n;
        z_q   <= z_n;
        cnt_q <= cnt_q + CW'(1);
        if (last_iter) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          out_i  <= IQ_W'(map_i);
          out_q  <= IQ_W'(map_q);
        end
      end
    end
  end

endmodule

// File: rtl/gmsk_mod.sv
`timescale 1ns/1ps
module gmsk_mod
  import gmsk_pkg::*;
#(
  parameter int OSR  = 4,
  parameter int SPAN = 3,
  parameter int PH_W = 16,
  parameter int IQ_W = 16,
  parameter int ITER = 14,
  parameter int AMP  = 30000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_bit,
  output logic                   out_valid,
  output logic signed [IQ_W-1:0] out_i,
  output logic signed [IQ_W-1:0] out_q
);

  localparam int SW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int FW = PH_W;

  mod_state_t           state_q;
  logic [SW-1:0]        sub_q;
  logic                 accept_evt;
  logic                 step_evt;
  logic                 sample_evt;
  logic                 last_sub;
  logic signed [FW-1:0] freq_w;
  logic [PH_W-1:0]      phase_q;

  assign in_ready   = (state_q == ST_IDLE);
  assign accept_evt = in_valid && in_ready;
  assign step_evt   = (state_q == ST_LAUNCH);
  assign last_sub   = (sub_q == SW'(OSR - 1));
  assign out_valid  = sample_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            sub_q   <= '0;
            state_q <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (sample_evt) begin
            if (last_sub) begin
              state_q <= ST_IDLE;
            end else begin
              sub_q   <= sub_q + SW'(1);
              state_q <= ST_LAUNCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  gmsk_shaper #(.OSR(OSR), .SPAN(SPAN), .FW(FW), .SW(SW)) u_shaper (
    .clk      (clk),
    .rst      (rst),
    .push     (accept_evt),
    .push_one (in_bit),
    .sub      (sub_q),
    .freq     (freq_w)
  );

  gmsk_phase_acc #(.PH_W(PH_W), .FW(FW)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .step  (step_evt),
    .freq  (freq_w),
    .phase (phase_q)
  );

  // The rotator takes the phase before this sample's increment lands.
  gmsk_cordic #(.PH_W(PH_W), .IQ_W(IQ_W), .ITER(ITER), .AMP(AMP)) u_cordic (
    .clk      (clk),
    .rst      (rst),
    .start    (step_evt),
    .phase_in (phase_q),
    .done     (sample_evt),
    .out_i    (out_i),
    .out_q    (out_q)
  );

endmodule

// File: rtl/gmsk_mod_chk.sv
`timescale 1ns/1ps
module gmsk_mod_chk #(
  parameter int OSR      = 4,
  parameter int PH_W     = 16,
  parameter int FW       = 16,
  parameter int IQ_W     = 16,
  parameter int AMP      = 30000,
  parameter int MAX_STEP = 4200
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic signed [IQ_W-1:0] out_i,
  input logic signed [IQ_W-1:0] out_q,
  input logic                   accept_evt,
  input logic                   step_evt,
  input logic [PH_W-1:0]        phase,
  input logic signed [FW-1:0]   freq
);

  localparam int LIM = AMP + 64;

  int   samp_cnt;
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)             samp_cnt <= OSR;
    else if (accept_evt) samp_cnt <= 0;
    else if (out_valid)  samp_cnt <= samp_cnt + 1;
  end

  p_closed_after_take_r1: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> !in_ready);

  p_ready_when_drained_r1: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> samp_cnt == OSR);

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_sample_budget_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> samp_cnt < OSR);

  p_step_bound_r5: assert property (@(posedge clk) disable iff (rst)
    step_evt |-> (int'(freq) <= MAX_STEP && int'(freq) >= -MAX_STEP));

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !step_evt |=> $stable(phase));

  p_envelope_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_i) <= LIM && int'(out_i) >= -LIM &&
                   int'(out_q) <= LIM && int'(out_q) >= -LIM));

  always @(posedge clk) begin
    if (rst_d && !rst) begin
      p_reset_state_r8: assert (phase == '0 && !out_valid && in_ready);
    end
  end

endmodule

bind gmsk_mod gmsk_mod_chk #(
  .OSR(OSR), .PH_W(PH_W), .FW(FW), .IQ_W(IQ_W), .AMP(AMP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_i      (out_i),
  .out_q      (out_q),
  .accept_evt (accept_evt),
  .step_evt   (step_evt),
  .phase      (phase_q),
  .freq       (freq_w)
);

// File: tb/test_gmsk_mod.sv
`timescale 1ns/1ps
module test_gmsk_mod;

  localparam int OSR = 4;
  localparam int AMP = 30000;
  localparam int TOL = 48;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, out_valid;
  logic signed [15:0] out_i, out_q;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int seed_val;

  // Bench copy of the pulse weights as stated in R4.
  int gtap [12] = '{156, 441, 985, 1711, 2333, 2566, 2566, 2333, 1711, 985, 441, 156};
  int lvl [3] = '{0, 0, 0};
  int mphase = 0;
  int exp_q [$];
  int cap_i [512];
  int cap_q [512];
  int cap_n = 0;

  gmsk_mod i_gmsk_mod (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #2.5 clk = ~clk;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int wrap16(int v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  function automatic int step_of(int k);
    int s = 0;
    for (int j = 0; j < 3; j++) s += lvl[j] * gtap[k + OSR * j];
    return s;
  endfunction

  function automatic int ideal(int ph, bit sine);
    real a;
    a = 6.283185307179586 * real'(ph) / 65536.0;
    return $rtoi($floor(real'(AMP) * (sine ? $sin(a) : $cos(a)) + 0.5));
  endfunction

  task automatic model_push(bit b);
    lvl[2] = lvl[1];
    lvl[1] = lvl[0];
    lvl[0] = b ? 1 : -1;
    for (int k = 0; k < OSR; k++) begin
      exp_q.push_back(mphase);
      mphase = wrap16(mphase + step_of(k));
    end
  endtask

  // Sample the outputs mid-cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "sample with none expected", 1, 0);
      end else begin
        int p;
        int ei;
        int eq;
        p  = exp_q.pop_front();
        ei = ideal(p, 1'b0);
        eq = ideal(p, 1'b1);
        check(iabs(int'(out_i) - ei) <= TOL, "R4/R6/R7", "I sample", int'(out_i), ei);
        check(iabs(int'(out_q) - eq) <= TOL, "R4/R6/R7", "Q sample", int'(out_q), eq);
      end
      if (cap_n < 512) begin
        cap_i[cap_n] = int'(out_i);
        cap_q[cap_n] = int'(out_q);
        cap_n++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1: got %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic send_bit(bit b);
    do @(negedge clk); while (!in_ready);
    check(exp_q.size() == 0, "R2", "samples missing at next take", exp_q.size(), 0);
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    in_valid = 1'b0;
    model_push(b);
    check(!in_ready, "R1", "ready right after take", int'(in_ready), 0);
  endtask

  task automatic wait_drain();
    do @(negedge clk); while (!in_ready || exp_q.size() != 0);
    @(negedge clk);
  endtask

  task automatic do_reset();
    wait_drain();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    lvl = '{0, 0, 0};
    mphase = 0;
    exp_q.delete();
    cap_n = 0;
    check(in_ready == 1'b1, "R8", "ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8", "strobe after reset", int'(out_valid), 0);
  endtask

  initial begin
    seed_val = $urandom(32'd4321);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(in_ready == 1'b1, "R8", "ready out of reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8", "strobe out of reset", int'(out_valid), 0);

    // Single one from reset: starts at (AMP,0) and turns counter-clockwise.
    send_bit(1'b1);
    wait_drain();
    check(cap_n == 4, "R2", "samples for one bit", cap_n, 4);
    check(iabs(cap_i[0] - AMP) <= TOL, "R8", "first I after reset", cap_i[0], AMP);
    check(iabs(cap_q[0]) <= TOL, "R8", "first Q after reset", cap_q[0], 0);
    check(cap_q[1] > 100, "R3", "Q sign for a one", cap_q[1], 448);

    // Single zero from reset turns clockwise.
    do_reset();
    send_bit(1'b0);
    wait_drain();
    check(cap_q[1] < -100, "R3", "Q sign for a zero", cap_q[1], -448);

    // Run of ones: quarter turn per full-window symbol, wrapping past a turn.
    do_reset();
    for (int n = 0; n < 10; n++) send_bit(1'b1);
    wait_drain();
    for (int m = 3; m < 10; m++) begin
      check(iabs(cap_i[4*m] + cap_q[4*(m-1)]) <= 2*TOL, "R5", "I after quarter turn",
            cap_i[4*m], -cap_q[4*(m-1)]);
      check(iabs(cap_q[4*m] - cap_i[4*(m-1)]) <= 2*TOL, "R5", "Q after quarter turn",
            cap_q[4*m], cap_i[4*(m-1)]);
    end

    // Alternating bits: partial pulses cancel, phase swings back and forth.
    do_reset();
    for (int n = 0; n < 16; n++) send_bit(n[0]);

    // Pairs of equal bits then flips, a pattern between the two extremes.
    for (int n = 0; n < 16; n++) send_bit(n[1]);

    // Random stream with a fixed seed.
    for (int n = 0; n < 400; n++) send_bit(1'($urandom() & 1));
    wait_drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule